// File: doc/BRIEF.md
# Three-Port Basic-Mode Parallel I/O Controller

This block gives a processor three 8-bit general-purpose parallel ports behind a small synchronous register interface. Each port has its own output latch, a single direction setting and a pin-input vector. The port pads are driven through separate output-data and output-enable vectors, so tristate buffers are left to the pad ring. All accesses are synchronous to one clock. Reads take effect at the clock edge where `reg_rd` is high, and `reg_rdata` holds the result from the next cycle until the next read.

The register at offset 3 accepts two kinds of write, chosen by bit 7. With bit 7 set, the write sets the direction of all three ports at once. With bit 7 clear, the write sets or clears one bit position in any chosen mix of ports A, B and C. Only the basic input/output mode exists: there is no handshake, no strobe and no interrupt. A port read always returns the live pin levels, whatever the direction setting.

The control interface has no back-pressure. Every strobe is accepted in the cycle it is presented, so no valid/ready pair is needed at this edge.

Top module: `pio_mode0`

## Requirements
- R1: After reset all three ports are inputs, `pad_oe` is all zero, every output latch is 0x00 and a control read returns 0x93.
- R2: A write to offset 0, 1 or 2 loads `reg_wdata` into the latch of port A, B or C at that clock edge. Each latch appears on its slice of `pad_out`: A in bits 7:0, B in bits 15:8, C in bits 23:16.
- R3: A write to offset 3 with bit 7 = 1 sets the directions: bit 4 for port A, bit 1 for port B and bit 0 for port C, where 1 = input and 0 = output. Bits 6:5, 3 and 2 have no effect.
- R4: A port's 8 output-enable bits are all high exactly when that port is set to output, and all low otherwise.
- R5: A latch keeps its value, and still accepts writes, while its port is an input. The value drives the pads again once the port is switched back to output.
- R6: A write to offset 3 with bit 7 = 0 is a set/clear command. Bit 0 is the new value (1 = set, 0 = clear) and bits 3:1 give the bit index. Bits 4, 5 and 6 enable the change on port A, B and C, and any combination may be used. Every other latch bit is left unchanged, and a command with no port selected changes nothing.
- R7: A read of offset 0, 1 or 2 returns that port's `pad_in` slice as it was at the read edge, whatever the direction setting. The value is valid on `reg_rdata` from the following cycle.
- R8: A read of offset 3 returns 0x80 with bit 4 = A direction, bit 1 = B direction and bit 0 = C direction.
- R9: A read and a write in the same cycle return the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register offset: 0 = A, 1 = B, 2 = C, 3 = control |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one access per high cycle |
| reg_rd | input | 1 | Read strobe, one access per high cycle |
| reg_rdata | output | 8 | Registered read data |
| pad_out | output | 24 | Output latches of ports C, B, A (from MSB to LSB) |
| pad_oe | output | 24 | Per-pin output enables, same layout |
| pad_in | input | 24 | Pin levels, same layout |

## Verification
The bench builds the block with its default parameters: three ports of eight bits. This is the only size the fixed control encoding allows, and it puts every one of the eight bit indices and all eight port-select combinations of the set/clear command within reach. Random sequences of data writes, direction writes, set/clear commands and reads are checked after every access against a bench model of the latches and directions. Directed cases cover reset values, ignored direction bits, an empty port selection, latch retention while a port is an input, and a read and a write in the same cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PW        = 8;
  localparam int NPORT     = 3;
  localparam int IDXW      = $clog2(PW);
  localparam int MODE_BIT  = 7;
  localparam int SEL_LSB   = 4;   // set/clear port-select bits 4..6
  localparam logic [1:0] CTRL_OFS = 2'd3;

  typedef struct packed {
    logic            data_we;
    logic            dir_we;
    logic            dir_in;
    logic            sc_we;
    logic [IDXW-1:0] sc_idx;
    logic            sc_val;
  } port_cmd_t;

  // direction bit position of each port inside a direction write
  function automatic int dir_pos(input int p);
    case (p)
      0:       dir_pos = 4;
      1:       dir_pos = 1;
      default: dir_pos = 0;
    endcase
  endfunction
endpackage

// File: rtl/pio_decode.sv
module pio_decode
  import pio_pkg::*;
(
  input  logic [1:0]    reg_addr,
  input  logic [PW-1:0] reg_wdata,
  input  logic          reg_wr,
  output port_cmd_t     cmd [NPORT]
);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == CTRL_OFS);

  for (genvar p = 0; p < NPORT; p++) begin : g_cmd
    always_comb begin
      cmd[p].data_we = reg_wr && (reg_addr == 2'(p));
      cmd[p].dir_we  = ctrl_wr && reg_wdata[MODE_BIT];
      cmd[p].dir_in  = reg_wdata[dir_pos(p)];
      cmd[p].sc_we   = ctrl_wr && !reg_wdata[MODE_BIT] && reg_wdata[SEL_LSB + p];
      cmd[p].sc_idx  = reg_wdata[IDXW:1];
      cmd[p].sc_val  = reg_wdata[0];
    end
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  port_cmd_t     cmd,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] latch_q,
  output logic          is_input
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      is_input <= 1'b1;
    end else begin
      if (cmd.data_we)
        latch_q <= wdata;
      else if (cmd.sc_we)
        latch_q[cmd.sc_idx] <= cmd.sc_val;
      if (cmd.dir_we)
        is_input <= cmd.dir_in;
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.data_we && !cmd.sc_we |=> $stable(latch_q)); // R5
  AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.data_we |=> latch_q == $past(wdata)); // R2
  AST_SC_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.data_we && cmd.sc_we |=> latch_q[$past(cmd.sc_idx)] == $past(cmd.sc_val)); // R6
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.dir_we |=> $stable(is_input)); // R3
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
  import pio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_rd,
  input  logic [1:0]          reg_addr,
  input  logic [NPORT*PW-1:0] pad_in,
  input  logic [NPORT-1:0]    dir_in,
  output logic [PW-1:0]       reg_rdata
);
  logic [PW-1:0] ctrl_word;
  logic [PW-1:0] sel_word;

  always_comb begin
    ctrl_word = '0;
    ctrl_word[MODE_BIT] = 1'b1;
    for (int p = 0; p < NPORT; p++)
      ctrl_word[dir_pos(p)] = dir_in[p];
  end

  always_comb begin
    sel_word = ctrl_word;
    for (int p = 0; p < NPORT; p++)
      if (reg_addr == 2'(p)) sel_word = pad_in[p*PW +: PW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= sel_word;
  end

  AST_RD_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == 2'd0 |=> reg_rdata == $past(pad_in[PW-1:0])); // R7
  AST_CTRL_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && reg_addr == CTRL_OFS |=> reg_rdata[MODE_BIT]); // R8
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata)); // R7
endmodule

// File: rtl/pio_mode0.sv
module pio_mode0
  import pio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          reg_addr,
  input  logic [PW-1:0]       reg_wdata,
  input  logic                reg_wr,
  input  logic                reg_rd,
  output logic [PW-1:0]       reg_rdata,
  output logic [NPORT*PW-1:0] pad_out,
  output logic [NPORT*PW-1:0] pad_oe,
  input  logic [NPORT*PW-1:0] pad_in
);
  port_cmd_t        cmd [NPORT];
  logic [NPORT-1:0] dir_in;

  pio_decode u_decode (
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_wr   (reg_wr),
    .cmd      (cmd)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pio_port u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd     (cmd[p]),
      .wdata   (reg_wdata),
      .latch_q (pad_out[p*PW +: PW]),
      .is_input(dir_in[p])
    );
    assign pad_oe[p*PW +: PW] = {PW{~dir_in[p]}};

    AST_OE_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pad_oe[p*PW +: PW]) == 0 || $countones(pad_oe[p*PW +: PW]) == PW); // R4
  end

  pio_rdmux u_rdmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .pad_in   (pad_in),
    .dir_in   (dir_in),
    .reg_rdata(reg_rdata)
  );
endmodule

// File: tb/pio_mode0_tb.sv
module pio_mode0_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic [23:0] pad_out, pad_oe, pad_in = '0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_lat [3];
  logic       m_dir [3];

  always #10 clk = ~clk;

  pio_mode0 u_dut (.*);

  function automatic logic [7:0] ctrl_word();
    return 8'h80 | ({7'd0, m_dir[0]} << 4) | ({7'd0, m_dir[1]} << 1) | {7'd0, m_dir[2]};
  endfunction

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_pads(input string tag);
    logic [23:0] eo, ee;
    for (int p = 0; p < 3; p++) begin
      eo[p*8 +: 8] = m_lat[p];
      ee[p*8 +: 8] = {8{~m_dir[p]}};
    end
    chk({tag, " R2 pad_out"}, pad_out, eo);
    chk({tag, " R4 pad_oe"}, pad_oe, ee);
  endtask

  task automatic model_wr(input logic [1:0] a, input logic [7:0] d);
    if (a != 2'd3) m_lat[a] = d;
    else if (d[7]) begin
      m_dir[0] = d[4]; m_dir[1] = d[1]; m_dir[2] = d[0];
    end else
      for (int p = 0; p < 3; p++) if (d[4+p]) m_lat[p][d[3:1]] = d[0];
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    e = (a == 2'd3) ? ctrl_word() : pad_in[a*8 +: 8];
    @(negedge clk); reg_rd = 1'b0;
    chk(tag, {16'd0, reg_rdata}, {16'd0, e});
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5671));
    for (int p = 0; p < 3; p++) begin m_lat[p] = 8'h00; m_dir[p] = 1'b1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_pads("R1 reset");
    rd(2'd3, "R1 R8 reset ctrl read 0x93");

    // R3: ignored bits set, all ports output
    wr(2'd3, 8'hEC); chk_pads("R3 ignored bits");
    rd(2'd3, "R3 R8 ctrl read");
    wr(2'd0, 8'hA5); wr(2'd1, 8'h3C); wr(2'd2, 8'h81);
    chk_pads("R2 port writes");
    // R5: switch A to input, write while input, back to output
    wr(2'd3, 8'h90); chk_pads("R5 A input");
    wr(2'd0, 8'h5A); chk_pads("R5 write while input");
    wr(2'd3, 8'h80); chk_pads("R5 A output again");
    // R6: no port selected, then all three at once
    wr(2'd3, 8'h0F); chk_pads("R6 empty select");
    wr(2'd3, 8'h7F); chk_pads("R6 set bit7 all ports");
    wr(2'd3, 8'h50); chk_pads("R6 clear bit0 A and C");
    // R7: pin reads in both directions
    pad_in = 24'h123456;
    rd(2'd0, "R7 read A output"); rd(2'd1, "R7 read B"); rd(2'd2, "R7 read C");
    // R9: read ctrl and write direction in the same cycle
    @(negedge clk); reg_addr = 2'd3; reg_wdata = 8'h93; reg_wr = 1'b1; reg_rd = 1'b1;
    begin
      logic [7:0] e9;
      e9 = ctrl_word();
      @(negedge clk); reg_wr = 1'b0; reg_rd = 1'b0;
      model_wr(2'd3, 8'h93);
      chk("R9 same-cycle read", {16'd0, reg_rdata}, {16'd0, e9});
    end
    chk_pads("R9 after write");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 4));
      pad_in = 24'($urandom);
      case (op)
        3'd0: wr(2'($urandom_range(0, 2)), 8'($urandom));
        3'd1: wr(2'd3, 8'h80 | 8'($urandom));
        3'd2: wr(2'd3, 8'h7F & 8'($urandom));
        3'd3: rd(2'($urandom_range(0, 2)), "R7 random pin read");
        default: rd(2'd3, "R8 random ctrl read");
      endcase
      chk_pads("R2 R3 R5 R6 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule